// File: doc/BRIEF.md
# Bulk Command Register-Write Decoder

The decoder takes a stream of command bytes, one per cycle over a valid/ready byte interface, and turns it into writes to a file of 8-bit registers with 8-bit addresses. Every command starts with a prefix byte (0xAF) and then a code byte. Two commands are recognised. The register write (code 0x20) carries an address byte and a data byte. The copy command (code 0x6A) carries seven argument bytes, and the decoder consumes it in full and discards it.

Software brackets a mode change with a lock and an unlock, both written to control address 0xFF. Register writes made while the lock is held are staged. The unlock applies all of them in the same cycle and raises a one-cycle commit pulse. Timing values, base addresses and the pixel clock are written byte by byte into adjacent registers. Most of these pairs put the high byte at the lower address, but the pixel-clock pair puts the low byte there. The decoder stores each byte at its own address whatever the group, so both orders come out as written.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: After reset every register reads 0x00, err_o and commit_o are low and no lock is held. A reset that comes while writes are staged discards them and releases the lock.
- R2: While unlocked, the bytes 0xAF, 0x20, A, D store D at address A. The new value is visible on reg_file_o (byte A at bits 8A+7..8A) after the clock edge that follows the edge accepting D, and not before it.
- R3: byte_ready_o is always high, and the decoder accepts one byte on every cycle in which byte_valid_i is high.
- R4: Writing 0x00 to address 0xFF starts a lock. Register writes made while the lock is held leave reg_file_o unchanged.
- R5: Writing 0xFF to address 0xFF commits all staged writes in the same cycle, and the last value staged for an address wins. commit_o is high for exactly one cycle on each such unlock.
- R6: Address 0xFF is never stored and always reads 0x00. Values other than 0x00 and 0xFF written to it have no effect: they neither lock nor unlock, and they raise no commit pulse.
- R7: A copy command (0xAF, 0x6A, then seven argument bytes) is consumed in full and changes no register, even when its argument bytes look like other commands.
- R8: A prefix byte that follows a prefix starts the command again. A lone trailing prefix has no effect and does not set err_o.
- R9: A byte other than 0xAF that arrives where a prefix is expected is dropped and sets err_o. err_o stays high until reset.
- R10: A prefix followed by a code byte that is neither 0x20 nor 0x6A nor 0xAF returns the decoder to idle without error, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Command byte valid |
| byte_data_i | input | 8 | Command byte |
| byte_ready_o | output | 1 | Byte accepted (always high) |
| reg_file_o | output | 2048 | Committed register contents, register A at bits 8A+7..8A |
| commit_o | output | 1 | One-cycle pulse on each unlock |
| err_o | output | 1 | Sticky flag for a byte where a prefix was expected |

## Verification
The bench fills a lock window with a multi-byte base address and a low-byte-first clock pair, and it writes one address twice. A decoder that leaked staged writes would change the outputs before the unlock, and one with a wrong overwrite rule would keep the stale byte. A copy command is sent whose arguments contain a complete register write. A decoder that miscounted the arguments would perform that write, or it would swallow the next real command. The bench also sends a doubled prefix, an unknown code, a stray data byte and a reset in the middle of a lock. A decoder that got these wrong would drop a valid write, flag an error it should not, forget the error, or leave the lock held after reset.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CODE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } dec_state_e;
endpackage

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
#(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned DATA_W         = 8,
  parameter logic [7:0]  PREFIX         = 8'hAF,
  parameter logic [7:0]  CODE_WR        = 8'h20,
  parameter logic [7:0]  CODE_COPY      = 8'h6A,
  parameter int unsigned COPY_ARG_BYTES = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              err_o
);
  localparam int unsigned CNT_W = $clog2(COPY_ARG_BYTES + 1);

  dec_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              wr_en_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_en_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (valid_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (data_i == PREFIX) state_q <= ST_CODE;
            else                  err_q   <= 1'b1;
          end
          ST_CODE: begin
            if (data_i == CODE_WR) begin
              state_q <= ST_ADDR;
            end else if (data_i == CODE_COPY) begin
              state_q <= ST_SKIP;
              cnt_q   <= CNT_W'(COPY_ARG_BYTES);
            end else if (data_i == PREFIX) begin
              state_q <= ST_CODE;  // restart on doubled prefix
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            addr_q  <= data_i[ADDR_W-1:0];
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= addr_q;
            wr_data_q <= data_i[DATA_W-1:0];
            state_q   <= ST_IDLE;
          end
          ST_SKIP: begin
            if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
            cnt_q <= cnt_q - CNT_W'(1);
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign err_o     = err_q;
endmodule

// File: rtl/bcd_regstage.sv
module bcd_regstage #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  LOCK_ADDR  = 8'hFF,
  parameter logic [7:0]  LOCK_VAL   = 8'h00,
  parameter logic [7:0]  UNLOCK_VAL = 8'hFF,
  localparam int unsigned NUM_REGS  = 1 << ADDR_W,
  localparam int unsigned FILE_W    = NUM_REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [FILE_W-1:0] file_o,
  output logic              locked_o,
  output logic              commit_o
);
  logic ctl_hit, do_lock, do_unlock;
  logic lock_q, commit_q;

  assign ctl_hit   = wr_en_i && (wr_addr_i == LOCK_ADDR[ADDR_W-1:0]);
  assign do_lock   = ctl_hit && (wr_data_i == LOCK_VAL[DATA_W-1:0]);
  assign do_unlock = ctl_hit && (wr_data_i == UNLOCK_VAL[DATA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= do_unlock;
      if (do_unlock)    lock_q <= 1'b0;
      else if (do_lock) lock_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == int'(LOCK_ADDR)) begin : g_ctl
      assign file_o[g*DATA_W +: DATA_W] = '0;
    end else begin : g_data
      logic [DATA_W-1:0] file_q, stage_q;
      logic              pend_q, sel;
      assign sel = wr_en_i && (wr_addr_i == ADDR_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          file_q  <= '0;
          stage_q <= '0;
          pend_q  <= 1'b0;
        end else if (do_unlock) begin
          if (pend_q) file_q <= stage_q;
          pend_q <= 1'b0;
        end else if (sel) begin
          if (lock_q) begin
            stage_q <= wr_data_i;
            pend_q  <= 1'b1;
          end else begin
            file_q <= wr_data_i;
          end
        end
      end
      assign file_o[g*DATA_W +: DATA_W] = file_q;
    end
  end

  assign locked_o = lock_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder #(
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned DATA_W         = 8,
  parameter logic [7:0]  PREFIX         = 8'hAF,
  parameter logic [7:0]  CODE_WR        = 8'h20,
  parameter logic [7:0]  CODE_COPY      = 8'h6A,
  parameter int unsigned COPY_ARG_BYTES = 7,
  parameter logic [7:0]  LOCK_ADDR      = 8'hFF,
  parameter logic [7:0]  LOCK_VAL       = 8'h00,
  parameter logic [7:0]  UNLOCK_VAL     = 8'hFF,
  localparam int unsigned NUM_REGS      = 1 << ADDR_W,
  localparam int unsigned FILE_W        = NUM_REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic [FILE_W-1:0] reg_file_o,
  output logic              commit_o,
  output logic              err_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              locked;

  assign byte_ready_o = 1'b1;

  bcd_parser #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PREFIX(PREFIX), .CODE_WR(CODE_WR),
    .CODE_COPY(CODE_COPY), .COPY_ARG_BYTES(COPY_ARG_BYTES)
  ) u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(byte_valid_i), .data_i(byte_data_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .err_o(err_o)
  );

  bcd_regstage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
    .LOCK_VAL(LOCK_VAL), .UNLOCK_VAL(UNLOCK_VAL)
  ) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .file_o(reg_file_o), .locked_o(locked), .commit_o(commit_o)
  );
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  PREFIX     = 8'hAF,
  parameter logic [7:0]  LOCK_ADDR  = 8'hFF,
  parameter logic [7:0]  UNLOCK_VAL = 8'hFF,
  parameter int unsigned FILE_W     = (1 << ADDR_W) * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_valid_i,
  input logic [7:0]        byte_data_i,
  input logic [FILE_W-1:0] reg_file_o,
  input logic              commit_o,
  input logic              err_o,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              locked
);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(byte_valid_i && (byte_data_i != PREFIX)));

  a_r5_commit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_en && (wr_addr == LOCK_ADDR[ADDR_W-1:0])
                       && (wr_data == UNLOCK_VAL[DATA_W-1:0])));

  a_r5_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_en && (wr_addr != LOCK_ADDR[ADDR_W-1:0])) |=> $stable(reg_file_o));

  a_r2_quiet_file: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(reg_file_o));
endmodule

bind bulk_cmd_decoder bcd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PREFIX(PREFIX),
  .LOCK_ADDR(LOCK_ADDR), .UNLOCK_VAL(UNLOCK_VAL), .FILE_W(FILE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i),
  .byte_data_i(byte_data_i), .reg_file_o(reg_file_o), .commit_o(commit_o),
  .err_o(err_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .locked(locked)
);

// File: tb/bulk_cmd_decoder_test.sv
`timescale 1ns/1ps
module bulk_cmd_decoder_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [7:0]    data = 8'h00;
  logic          ready, commit, err;
  logic [2047:0] regs;

  int checks = 0;
  int fails = 0;
  int commit_cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bulk_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_data_i(data),
    .byte_ready_o(ready), .reg_file_o(regs), .commit_o(commit), .err_o(err)
  );

  always @(negedge clk) if (rst_n && commit) commit_cycles++;

  function automatic logic [7:0] rd(input int a);
    return regs[a*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    valid = 1'b1;
    data  = b;
    @(posedge clk);
    #1;
    valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 reg00", rd(0), 0);
    check("R1 reg20", rd(8'h20), 0);
    check("R1 err", err, 0);
    check("R1 commit", commit, 0);
    check("R3 ready", ready, 1);
  endtask

  task automatic t_write();
    wr(8'h10, 8'h5A);
    check("R2 not before edge", rd(8'h10), 0);
    @(posedge clk); #1;
    check("R2 latency", rd(8'h10), 8'h5A);
    send(8'hAF); send(8'h20); send(8'h11); send(8'hC3); send(8'hAF); send(8'h20);
    send(8'h12); send(8'h3C);
    settle();
    check("R3 back-to-back a", rd(8'h11), 8'hC3);
    check("R3 back-to-back b", rd(8'h12), 8'h3C);
  endtask

  task automatic t_lock();
    int c0 = commit_cycles;
    wr(8'hFF, 8'h00);
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h30, 8'h20); wr(8'h31, 8'h4E);
    wr(8'h20, 8'h99);
    settle();
    check("R4 held 20", rd(8'h20), 0);
    check("R4 held 31", rd(8'h31), 0);
    check("R4 no commit", commit_cycles, c0);
    wr(8'hFF, 8'hFF);
    check("R5 before commit", rd(8'h21), 0);
    @(posedge clk); #1;
    check("R5 commit pulse", commit, 1);
    check("R5 20 last wins", rd(8'h20), 8'h99);
    check("R5 21", rd(8'h21), 8'h34);
    check("R5 22", rd(8'h22), 8'h56);
    check("R5 clk low byte", rd(8'h30), 8'h20);
    check("R5 clk high byte", rd(8'h31), 8'h4E);
    settle();
    check("R5 one-cycle pulse", commit_cycles, c0 + 1);
    wr(8'h23, 8'h77);
    settle();
    check("R5 unlocked again", rd(8'h23), 8'h77);
  endtask

  task automatic t_ctl_reg();
    int c0 = commit_cycles;
    wr(8'hFF, 8'h42);
    wr(8'h40, 8'h01);
    settle();
    check("R6 ff reads zero", rd(8'hFF), 0);
    check("R6 no lock", rd(8'h40), 8'h01);
    check("R6 no commit", commit_cycles, c0);
  endtask

  task automatic t_copy();
    send(8'hAF); send(8'h6A);
    send(8'hAF); send(8'h20); send(8'h10); send(8'h77);
    send(8'hAF); send(8'h20); send(8'h10);
    wr(8'h13, 8'hEE);
    settle();
    check("R7 no disturb", rd(8'h10), 8'h5A);
    check("R7 next cmd", rd(8'h13), 8'hEE);
    check("R7 no err", err, 0);
  endtask

  task automatic t_prefix();
    send(8'hAF); send(8'hAF); send(8'h20); send(8'h44); send(8'h01);
    settle();
    check("R8 double prefix", rd(8'h44), 8'h01);
    send(8'hAF);
    settle();
    check("R8 trailing prefix", err, 0);
    send(8'h55);
    wr(8'h45, 8'h02);
    settle();
    check("R10 unknown code", rd(8'h45), 8'h02);
    check("R10 no err", err, 0);
  endtask

  task automatic t_err();
    send(8'h13);
    settle();
    check("R9 err set", err, 1);
    check("R9 byte dropped", rd(8'h13), 8'hEE);
    wr(8'h46, 8'h03);
    settle();
    check("R9 resync", rd(8'h46), 8'h03);
    check("R9 sticky", err, 1);
  endtask

  task automatic t_reset_mid_lock();
    wr(8'hFF, 8'h00);
    wr(8'h50, 8'hAB);
    settle();
    rst_n = 1'b0;
    #7;
    rst_n = 1'b1;
    settle();
    check("R1 regs cleared", rd(8'h46), 0);
    check("R1 err cleared", err, 0);
    wr(8'h51, 8'hCD);
    settle();
    check("R1 lock released", rd(8'h51), 8'hCD);
    check("R1 staged dropped", rd(8'h50), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    t_reset();
    t_write();
    t_lock();
    t_ctl_reg();
    t_copy();
    t_prefix();
    t_err();
    t_reset_mid_lock();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule